// File: doc/BRIEF.md
# Chipset Shadow Memory Configuration Unit

This block is the configuration side of a host bridge. It holds a 256-byte configuration space behind a simple byte-wide register bus. The identification bytes are fixed. Only the command/status window and the device-specific area above offset 0x40 take writes. Two device-specific bytes control how the upper memory area from 0xC0000 to 0xFFFFF is served. The shadow-enable byte sits at offset 0x44 and the routing byte at offset 0x45.

The upper memory area is cut into eight 32 KB segments. For every memory access, the block looks at the address and the read/write direction. It then says on `mem_internal` whether the access belongs to on-board DRAM (1) or to the external bus (0). A secondary bus-reset pulse turns off shadowing of the four top segments, which hold the system firmware, and leaves the lower four alone. `bios_shadow_on` reports whether any firmware segment is shadowed.

Register reads are handled by a two-state machine. `RD_IDLE` is the resting state. When `cfg_rd` is high it takes the transition *issue* to `RD_RESP`. `RD_RESP` presents the data and takes *chain* back to itself when another read is issued, or *retire* to `RD_IDLE` otherwise. From `RD_IDLE` with no read it takes *hold* and stays. Reset enters `RD_IDLE`.

Top module: `shadow_cfg_unit`

## Requirements
- R1: After reset, the bytes at offsets 0x00..0x0B read 0x39, 0x10, 0x96, 0x04, 0x07, 0x00, 0x80, 0x02, 0x02, 0x00, 0x00, 0x06. Every other offset reads 0x00.
- R2: A read strobe in cycle t gives `cfg_rvalid`=1 in cycle t+1. `cfg_rdata` then holds the byte that was stored at `cfg_addr` before any write in cycle t. With no strobe, `cfg_rvalid` is 0 in the next cycle.
- R3: A write to offsets 0x04..0x07 or 0x40..0xFF stores `cfg_wdata`, and a later read returns it.
- R4: A write to offsets 0x00..0x03 or 0x08..0x3F has no effect: these bytes keep their reset values.
- R5: An address A in 0xC0000..0xFFFFF lies in segment n = A[17:15]. When bit n of offset 0x44 is 0, both reads and writes of A give `mem_internal`=0.
- R6: When bit n of 0x44 is 1, bits [1:0] of offset 0x45 choose the routing (`mem_wr`=1 means write). Code 0 sends reads external and writes internal. Code 1 sends both external. Code 2 sends both internal. Code 3 sends reads internal and writes external.
- R7: An address below 0xC0000 or above 0xFFFFF always gives `mem_internal`=1.
- R8: A `bus_reset` pulse clears bits [7:4] of 0x44 by the next cycle and keeps bits [3:0]. If a write to 0x44 comes in the same cycle, the written low bits are stored and the high bits still clear.
- R9: `bios_shadow_on` is 1 exactly when any of bits [7:4] of 0x44 is 1.
- R10: The decode follows the stored bytes combinationally. A write to 0x44 or 0x45 changes `mem_internal` from the next cycle on, not in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data, registered |
| cfg_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| bus_reset | input | 1 | Secondary bus-reset pulse |
| mem_addr | input | ADDR_W | Memory access address |
| mem_wr | input | 1 | Access direction: 1 write, 0 read |
| mem_internal | output | 1 | 1 routes the access to internal DRAM, 0 to the external bus |
| bios_shadow_on | output | 1 | Any firmware segment shadowed |

## Verification
`mem_internal` and `bios_shadow_on` are combinational from the stored bytes. The bench therefore compares them against its model just after each falling edge, before the rising edge that would commit that cycle's write or bus reset. This means a write is seen only from the following cycle. Read data is due one rising edge after the strobe. So the model captures the expected byte at that edge, from its contents before the same-cycle write, and compares `cfg_rvalid` and `cfg_rdata` at the next falling edge. A bus reset or a write to 0x44 lands in the model at the rising edge. Its effect on the flag is checked from the next cycle.

// File: rtl/shcfg_pkg.sv
package shcfg_pkg;

    localparam int CFG_BYTES   = 256;
    localparam int CFG_AW      = 8;
    localparam int SHADOW_EN_OFF = 8'h44;
    localparam int ROUTE_OFF     = 8'h45;

    typedef enum logic [1:0] {
        RT_RDEXT_WRINT = 2'd0,
        RT_BOTH_EXT    = 2'd1,
        RT_BOTH_INT    = 2'd2,
        RT_RDINT_WREXT = 2'd3
    } route_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    // Byte value held after reset at a given offset.
    function automatic logic [7:0] fixed_byte(input int idx);
        logic [7:0] v;
        case (idx)
            0:  v = 8'h39;
            1:  v = 8'h10;
            2:  v = 8'h96;
            3:  v = 8'h04;
            4:  v = 8'h07;
            6:  v = 8'h80;
            7:  v = 8'h02;
            8:  v = 8'h02;
            11: v = 8'h06;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic bit cfg_writable(input int idx);
        return (idx >= 4 && idx < 8) || (idx >= 8'h40);
    endfunction

endpackage

// File: rtl/shcfg_regfile.sv
module shcfg_regfile
    import shcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              bus_reset,
    input  logic [CFG_AW-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    output logic [7:0]        shadow_en,
    output logic [1:0]        route_code
);
    logic [7:0] bytes_w [CFG_BYTES];

    for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
        if (cfg_writable(i)) begin : g_rw
            localparam bit IS_EN = (i == SHADOW_EN_OFF);
            logic [7:0] q;
            logic [7:0] nxt;
            always_comb begin
                nxt = q;
                if (wr_en && (wr_addr == CFG_AW'(i))) nxt = wr_data;
                if (IS_EN && bus_reset) nxt = nxt & 8'h0F;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) q <= fixed_byte(i);
                else        q <= nxt;
            end
            assign bytes_w[i] = q;
        end else begin : g_ro
            assign bytes_w[i] = fixed_byte(i);
        end
    end

    assign rd_byte    = bytes_w[rd_addr];
    assign shadow_en  = bytes_w[SHADOW_EN_OFF];
    assign route_code = bytes_w[ROUTE_OFF][1:0];

endmodule

// File: rtl/shcfg_seg_decode.sv
module shcfg_seg_decode
    import shcfg_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int REGION_BASE = 32'h000C_0000,
    parameter int SEG_SHIFT   = 15,
    parameter int SEG_COUNT   = 8
) (
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wr,
    input  logic [7:0]        shadow_en,
    input  logic [1:0]        route_code,
    output logic              mem_internal
);
    localparam int SEG_BITS = $clog2(SEG_COUNT);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(REGION_BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(REGION_BASE + (SEG_COUNT << SEG_SHIFT) - 1);

    logic                in_region;
    logic [SEG_BITS-1:0] seg;
    logic                seg_on;

    assign in_region = (mem_addr >= LO) && (mem_addr <= HI);
    assign seg       = mem_addr[SEG_SHIFT +: SEG_BITS];
    assign seg_on    = shadow_en[seg];

    always_comb begin
        if (!in_region) begin
            mem_internal = 1'b1;
        end else if (!seg_on) begin
            mem_internal = 1'b0;
        end else begin
            unique case (route_e'(route_code))
                RT_RDEXT_WRINT: mem_internal = mem_wr;
                RT_BOTH_EXT:    mem_internal = 1'b0;
                RT_BOTH_INT:    mem_internal = 1'b1;
                RT_RDINT_WREXT: mem_internal = !mem_wr;
            endcase
        end
    end

endmodule

// File: rtl/shcfg_rd_fsm.sv
module shcfg_rd_fsm
    import shcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_req,
    input  logic [7:0] rd_byte,
    output logic [7:0] rdata,
    output logic       rvalid
);
    rd_state_e state_q, state_d;
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = rd_req ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_req ? RD_RESP : RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= 8'h00;
        else if (rd_req) rdata_q <= rd_byte;
    end

    assign rdata  = rdata_q;
    assign rvalid = (state_q == RD_RESP);

endmodule

// File: rtl/shadow_cfg_unit.sv
module shadow_cfg_unit
    import shcfg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              cfg_rvalid,
    input  logic              bus_reset,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wr,
    output logic              mem_internal,
    output logic              bios_shadow_on
);
    logic [7:0] rd_byte_w;
    logic [7:0] shadow_en_w;
    logic [1:0] route_w;

    shcfg_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr),
        .wr_addr    (cfg_addr),
        .wr_data    (cfg_wdata),
        .bus_reset  (bus_reset),
        .rd_addr    (cfg_addr),
        .rd_byte    (rd_byte_w),
        .shadow_en  (shadow_en_w),
        .route_code (route_w)
    );

    shcfg_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .mem_addr     (mem_addr),
        .mem_wr       (mem_wr),
        .shadow_en    (shadow_en_w),
        .route_code   (route_w),
        .mem_internal (mem_internal)
    );

    shcfg_rd_fsm u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (cfg_rd),
        .rd_byte (rd_byte_w),
        .rdata   (cfg_rdata),
        .rvalid  (cfg_rvalid)
    );

    assign bios_shadow_on = |shadow_en_w[7:4];

endmodule

// File: rtl/shcfg_checker.sv
module shcfg_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_rd,
    input logic              cfg_wr,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_rdata,
    input logic              cfg_rvalid,
    input logic              bus_reset,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_internal,
    input logic              bios_shadow_on,
    input logic [7:0]        shadow_en
);
    logic in_upper;
    assign in_upper = (mem_addr >= ADDR_W'(32'h000C_0000)) && (mem_addr <= ADDR_W'(32'h000F_FFFF));

    p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> cfg_rvalid);
    p_rvalid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> !cfg_rvalid);
    p_vendor_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == 8'h00) |=> (cfg_rdata == 8'h39));
    p_outside_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_upper |-> mem_internal);
    p_seg_off_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_upper && !shadow_en[mem_addr[17:15]]) |-> !mem_internal);
    p_busrst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !bios_shadow_on);
    p_busrst_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !cfg_wr) |=> (shadow_en[3:0] == $past(shadow_en[3:0])));

endmodule

bind shadow_cfg_unit shcfg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_rd         (cfg_rd),
    .cfg_wr         (cfg_wr),
    .cfg_addr       (cfg_addr),
    .cfg_rdata      (cfg_rdata),
    .cfg_rvalid     (cfg_rvalid),
    .bus_reset      (bus_reset),
    .mem_addr       (mem_addr),
    .mem_internal   (mem_internal),
    .bios_shadow_on (bios_shadow_on),
    .shadow_en      (shadow_en_w)
);

// File: tb/shadow_cfg_unit_tb.sv
`timescale 1ns/1ps
module shadow_cfg_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0, bus_reset = 1'b0, mem_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00, cfg_wdata = 8'h00;
    logic [31:0] mem_addr = 32'h0;
    logic [7:0]  cfg_rdata;
    logic        cfg_rvalid, mem_internal, bios_shadow_on;

    int total = 0;
    int bad = 0;
    int mdl [256];
    bit exp_rvalid = 0;
    int exp_rdata = 0;
    bit after_cfg = 0;

    always #4 clk = ~clk;

    shadow_cfg_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rvalid(cfg_rvalid), .bus_reset(bus_reset), .mem_addr(mem_addr),
        .mem_wr(mem_wr), .mem_internal(mem_internal), .bios_shadow_on(bios_shadow_on)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 256; i++) mdl[i] = 0;
        mdl[0] = 'h39; mdl[1] = 'h10; mdl[2] = 'h96; mdl[3] = 'h04;
        mdl[4] = 'h07; mdl[6] = 'h80; mdl[7] = 'h02; mdl[8] = 'h02; mdl[11] = 'h06;
    endfunction

    function automatic int exp_route(input longint a, input bit w);
        int seg;
        if (a < 'hC0000 || a > 'hFFFFF) return 1;
        seg = int'((a - 'hC0000) / 'h8000);
        if (((mdl['h44] >> seg) & 1) == 0) return 0;
        case (mdl['h45] & 3)
            0: return w ? 1 : 0;
            1: return 0;
            2: return 1;
            default: return w ? 0 : 1;
        endcase
    endfunction

    function automatic string route_req(input longint a);
        int seg;
        if (after_cfg) return "R10";
        if (a < 'hC0000 || a > 'hFFFFF) return "R7";
        seg = int'((a - 'hC0000) / 'h8000);
        if (((mdl['h44] >> seg) & 1) == 0) return "R5";
        return "R6";
    endfunction

    // One clock: drive, check combinational outputs, commit model, check read port.
    task automatic step(input bit wr, input bit rd, input int addr, input int wd,
                        input bit br, input longint ma, input bit mw);
        bit cfg_hit;
        cfg_wr = wr; cfg_rd = rd; cfg_addr = addr[7:0]; cfg_wdata = wd[7:0];
        bus_reset = br; mem_addr = ma[31:0]; mem_wr = mw;
        #1;
        check(route_req(ma), int'(mem_internal), exp_route(ma, mw));
        check("R9", int'(bios_shadow_on), ((mdl['h44] & 'hF0) != 0) ? 1 : 0);
        @(posedge clk);
        exp_rvalid = rd;
        if (rd) exp_rdata = mdl[addr];
        cfg_hit = wr && (addr == 'h44 || addr == 'h45);
        if (wr && ((addr >= 4 && addr < 8) || addr >= 'h40)) mdl[addr] = wd & 'hFF;
        if (br) mdl['h44] = mdl['h44] & 'h0F;
        after_cfg = cfg_hit;
        @(negedge clk);
        check("R2", int'(cfg_rvalid), int'(exp_rvalid));
        if (exp_rvalid) begin
            if (addr < 'h0C) check("R1", int'(cfg_rdata), exp_rdata);
            else if ((addr >= 4 && addr < 8) || addr >= 'h40) check("R3", int'(cfg_rdata), exp_rdata);
            else check("R4", int'(cfg_rdata), exp_rdata);
        end
    endtask

    task automatic idle(input longint ma, input bit mw);
        step(0, 0, 0, 0, 0, ma, mw);
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R2", int'(cfg_rvalid), 0);
        // R1: every offset holds its reset value
        for (int a = 0; a < 256; a++) step(0, 1, a, 0, 0, 'h0, 0);
        // R3 / R4: write a pattern everywhere except the shadow bytes, read it back
        for (int a = 0; a < 256; a++)
            if (a != 'h44 && a != 'h45) step(1, 0, a, (a * 7 + 3) & 'hFF, 0, 'h1000, 1);
        for (int a = 0; a < 256; a++) step(0, 1, a, 0, 0, 'hBFFFF, 0);
        // R2: read in the same cycle as a write returns old byte, next read new
        step(1, 1, 'h50, 'hA5, 0, 'h0, 0);
        step(0, 1, 'h50, 0, 0, 'h0, 0);
        // R5 / R6 / R10: each routing code with alternating enable patterns
        for (int code = 0; code < 4; code++) begin
            for (int pat = 0; pat < 3; pat++) begin
                int en;
                en = (pat == 0) ? 'hA5 : (pat == 1) ? 'h5A : 'hFF;
                step(1, 0, 'h44, en, 0, 'hC0000, 0);
                step(1, 0, 'h45, code | 'hFC, 0, 'hC8000, 1);
                for (int s = 0; s < 8; s++) begin
                    longint base;
                    base = 'hC0000 + s * 'h8000;
                    idle(base, 0);
                    idle(base, 1);
                    idle(base + 'h7FFF, 0);
                    idle(base + 'h7FFF, 1);
                end
                // R7: just outside the window
                idle('hBFFFF, 0); idle('hBFFFF, 1);
                idle('h100000, 0); idle('h100000, 1);
                idle('hFFFFF, 1);
            end
        end
        // R8: bus reset keeps low enables, clears high ones
        step(1, 0, 'h44, 'hFF, 0, 'hF0000, 0);
        step(0, 0, 0, 0, 1, 'hF8000, 0);
        step(0, 1, 'h44, 0, 0, 'hC0000, 0);
        check("R8", int'(cfg_rdata), 'h0F);
        // R8: bus reset together with a write to the enable byte
        step(1, 0, 'h44, 'hC3, 1, 'hE0000, 1);
        step(0, 1, 'h44, 0, 0, 'hD8000, 1);
        check("R8", int'(cfg_rdata), 'h03);
        // R9: single high enable bit
        step(1, 0, 'h44, 'h10, 0, 'h0, 0);
        idle('hE0000, 0);
        step(1, 0, 'h44, 'h08, 0, 'h0, 0);
        idle('hD8000, 1);
        idle(0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule